// File: doc/BRIEF.md
# Up/Down Binary Counter with Shared Bidirectional Data Port

The block is a synchronous binary counter, eight bits wide by default, that counts up or down under a direction input. A single bidirectional data port serves two roles: it carries a preset value into the counter during a parallel load, and it returns the current count to the bus when the block is selected for reading. The tri-state port is modelled as a data-in vector, a data-out vector and a drive-enable flag. The top level of a chip turns these into a real pad.

Control inputs are resolved in a fixed priority. An asynchronous master clear comes first, then a synchronous clear, then the parallel load, then the two count enables. An active-low terminal-count output reaches its active level at the last state in the current direction. Because this output follows the trickle enable and the direction input combinationally, several counters can be chained with carry lookahead.

Top module: `updn_bus_counter`

## Requirements
- R1: While `rst_an` is low the count is 0, at once and without a clock edge; this overrides every other input.
- R2: With `rst_an` high and `srst_n` low, the count becomes 0 on the next rising edge, even when a load is requested.
- R3: With both resets inactive and `sel_n` = 0 and `load_n` = 0, the count takes `bus_in` on the rising edge, whatever the count enables are. If either `sel_n` or `load_n` is high, no load happens.
- R4: `bus_oe` is 1 exactly when `sel_n` = 0, `load_n` = 1 and `oe_n` = 0. While `bus_oe` is 1, `bus_out` equals the count.
- R5: When no load is active and `cnt_en_p_n` is high, the count holds its value.
- R6: When no load is active and `cnt_en_t_n` is high, the count holds its value and `tc_n` is 1.
- R7: With both count enables low, the count rises by one when `up` = 1 and falls by one when `up` = 0. It wraps modulo 2^WIDTH (255 to 0 going up, 0 to 255 going down).
- R8: `tc_n` is 0 exactly when `cnt_en_t_n` = 0 and either `up` = 1 with the count at 255, or `up` = 0 with the count at 0. It follows a change of `up` with no clock edge.
- R9: `bus_oe` is never 1 while `load_n` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous state changes on the rising edge |
| rst_an | input | 1 | Asynchronous clear, active low |
| srst_n | input | 1 | Synchronous clear, active low |
| sel_n | input | 1 | Block select, active low |
| load_n | input | 1 | Parallel load request, active low |
| cnt_en_p_n | input | 1 | Count enable that gates only the counter, active low |
| cnt_en_t_n | input | 1 | Count enable that also gates terminal count, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| oe_n | input | 1 | Read drive enable, active low |
| bus_in | input | WIDTH | Value seen on the shared port |
| bus_out | output | WIDTH | Value the block drives onto the shared port |
| bus_oe | output | 1 | 1 when the block drives the shared port |
| tc_n | output | 1 | Terminal count, active low |

## Verification
Counting is tried in both directions across both wrap points (253 up through 0, then back down to 254). This separates correct modulo arithmetic from saturation or sign errors, and `tc_n` is observed at each step so that a comparison against the wrong end value shows up. The control patterns combine a load with active count enables, a clear with an active load, a load with the block deselected, and each count enable held off on its own. Together they expose a wrong priority order or a missing select qualifier. The bus gating is swept over the select, load and output-enable combinations. A direction flip between clock edges confirms that `tc_n` is combinational.

// File: rtl/ubc_pkg.sv
package ubc_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_CLEAR = 3'd1,
        OP_LOAD  = 3'd2,
        OP_INC   = 3'd3,
        OP_DEC   = 3'd4
    } ubc_op_e;
endpackage

// File: rtl/ubc_op_decode.sv
module ubc_op_decode
    import ubc_pkg::*;
(
    input  logic    srst_n,
    input  logic    sel_n,
    input  logic    load_n,
    input  logic    cnt_en_p_n,
    input  logic    cnt_en_t_n,
    input  logic    up,
    output ubc_op_e op
);
    // Priority: synchronous clear, then load, then the count enables.
    always_comb begin
        if (!srst_n)
            op = OP_CLEAR;
        else if (!sel_n && !load_n)
            op = OP_LOAD;
        else if (cnt_en_p_n || cnt_en_t_n)
            op = OP_HOLD;
        else if (up)
            op = OP_INC;
        else
            op = OP_DEC;
    end
endmodule

// File: rtl/ubc_count_reg.sv
module ubc_count_reg
    import ubc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_an,
    input  ubc_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count_q
);
    typedef struct packed {
        logic [WIDTH-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_CLEAR: st_d.count = '0;
            OP_LOAD:  st_d.count = din;
            OP_INC:   st_d.count = st_q.count + WIDTH'(1);
            OP_DEC:   st_d.count = st_q.count - WIDTH'(1);
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_an) begin
        if (!rst_an)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign count_q = st_q.count;
endmodule

// File: rtl/ubc_tc_detect.sv
module ubc_tc_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] count,
    input  logic             up,
    input  logic             cnt_en_t_n,
    output logic             tc_n
);
    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

    logic at_end;

    always_comb begin
        at_end = up ? (count == TOP_VAL) : (count == '0);
        tc_n   = !(at_end && !cnt_en_t_n);
    end
endmodule

// File: rtl/ubc_bus_gate.sv
module ubc_bus_gate #(
    parameter int WIDTH = 8
) (
    input  logic             sel_n,
    input  logic             load_n,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe
);
    // Driving during a load is never allowed: load_n low forces release.
    always_comb begin
        bus_oe  = !sel_n && load_n && !oe_n;
        bus_out = bus_oe ? count : '0;
    end
endmodule

// File: rtl/updn_bus_counter.sv
module updn_bus_counter
    import ubc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_an,
    input  logic             srst_n,
    input  logic             sel_n,
    input  logic             load_n,
    input  logic             cnt_en_p_n,
    input  logic             cnt_en_t_n,
    input  logic             up,
    input  logic             oe_n,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             tc_n
);
    localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

    ubc_op_e          op;
    logic [WIDTH-1:0] count_q;
    logic             load_req;

    assign load_req = !sel_n && !load_n;

    ubc_op_decode u_decode (
        .srst_n     (srst_n),
        .sel_n      (sel_n),
        .load_n     (load_n),
        .cnt_en_p_n (cnt_en_p_n),
        .cnt_en_t_n (cnt_en_t_n),
        .up         (up),
        .op         (op)
    );

    ubc_count_reg #(.WIDTH(WIDTH)) u_count (
        .clk     (clk),
        .rst_an  (rst_an),
        .op      (op),
        .din     (bus_in),
        .count_q (count_q)
    );

    ubc_tc_detect #(.WIDTH(WIDTH)) u_tc (
        .count      (count_q),
        .up         (up),
        .cnt_en_t_n (cnt_en_t_n),
        .tc_n       (tc_n)
    );

    ubc_bus_gate #(.WIDTH(WIDTH)) u_bus (
        .sel_n   (sel_n),
        .load_n  (load_n),
        .oe_n    (oe_n),
        .count   (count_q),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    p_sync_clear_r2: assert property (@(posedge clk) disable iff (!rst_an)
        !srst_n |=> count_q == '0);

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_an)
        (srst_n && load_req) |=> count_q == $past(bus_in));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_an)
        (srst_n && !load_req && (cnt_en_p_n || cnt_en_t_n)) |=> $stable(count_q));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_an)
        (srst_n && !load_req && !cnt_en_p_n && !cnt_en_t_n && up)
        |=> count_q == WIDTH'($past(count_q) + WIDTH'(1)));

    p_wrap_after_tc_r8: assert property (@(posedge clk) disable iff (!rst_an)
        (!tc_n && srst_n && !load_req && !cnt_en_p_n)
        |=> (count_q == '0 || count_q == TOP_VAL));

    p_bus_value_r4: assert property (@(posedge clk) disable iff (!rst_an)
        bus_oe |-> bus_out == count_q);

    p_no_drive_load_r9: assert property (@(posedge clk) disable iff (!rst_an)
        !load_n |-> !bus_oe);
endmodule

// File: tb/updn_bus_counter_bench.sv
module updn_bus_counter_bench;
    localparam int W = 8;

    typedef struct packed {
        logic         srst_n;
        logic         sel_n;
        logic         load_n;
        logic         cep_n;
        logic         cet_n;
        logic         up;
        logic [W-1:0] din;
        logic [W-1:0] exp_cnt;
        logic         exp_tc_n;
    } vec_t;

    localparam int NV = 14;
    //                       srst sel load cep cet up  din    cnt    tc
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 8'hFD, 8'hFD, 1'b1}, // R3 load, R6 tc forced
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'h00, 8'hFE, 1'b1}, // R7 up
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'h00, 8'hFF, 1'b0}, // R8 top while up
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b1, 8'h00, 8'h00, 1'b1}, // R7 wrap up
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 8'hFF, 1'b1}, // R7 wrap down
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 8'hFE, 1'b1}, // R7 down
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'h00, 8'hFE, 1'b1}, // R5 hold
        '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h01, 8'h01, 1'b1}, // R3 load beats count
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 8'h00, 1'b0}, // R8 zero while down
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 8'h00, 8'h00, 1'b1}, // R6 hold, tc high
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h55, 8'h00, 1'b1}, // R2 clear beats load
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'h80, 8'h01, 1'b1}, // R3 no load when deselected
        '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1, 8'h80, 8'h80, 1'b1}, // R3 load
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 8'h00, 8'h00, 1'b0}  // R2 clear
    };

    logic         clk = 1'b0;
    logic         rst_an = 1'b1;
    logic         srst_n = 1'b1, sel_n = 1'b1, load_n = 1'b1;
    logic         cnt_en_p_n = 1'b1, cnt_en_t_n = 1'b1, up = 1'b1, oe_n = 1'b1;
    logic [W-1:0] bus_in = '0;
    logic [W-1:0] bus_out;
    logic         bus_oe, tc_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    updn_bus_counter #(.WIDTH(W)) u_updn_bus_counter (
        .clk(clk), .rst_an(rst_an), .srst_n(srst_n), .sel_n(sel_n),
        .load_n(load_n), .cnt_en_p_n(cnt_en_p_n), .cnt_en_t_n(cnt_en_t_n),
        .up(up), .oe_n(oe_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .tc_n(tc_n)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Put the port in read mode with the counter held, then sample.
    task automatic read_back(input string tag, input logic cet, input logic dir,
                             input logic [W-1:0] exp_cnt, input logic exp_tc);
        sel_n = 1'b0; load_n = 1'b1; oe_n = 1'b0; cnt_en_p_n = 1'b1;
        cnt_en_t_n = cet; up = dir; srst_n = 1'b1;
        #2;
        check({tag, " bus_oe"}, W'(bus_oe), W'(1'b1));
        check({tag, " count"}, bus_out, exp_cnt);
        check({tag, " tc_n"}, W'(tc_n), W'(exp_tc));
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #2 rst_an = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state: count 0, down with trickle on gives tc low
        read_back("R1 reset", 1'b0, 1'b0, 8'h00, 1'b0);
        @(negedge clk);
        rst_an = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            srst_n = VECS[i].srst_n; sel_n = VECS[i].sel_n; load_n = VECS[i].load_n;
            cnt_en_p_n = VECS[i].cep_n; cnt_en_t_n = VECS[i].cet_n;
            up = VECS[i].up; bus_in = VECS[i].din; oe_n = 1'b1;
            @(posedge clk);
            #5;
            read_back($sformatf("vec %0d R2/R3/R5/R6/R7/R8", i), VECS[i].cet_n,
                      VECS[i].up, VECS[i].exp_cnt, VECS[i].exp_tc_n);
            @(negedge clk);
        end

        // R8: tc follows direction with no clock edge (count is 0 here)
        read_back("R8 up at zero", 1'b0, 1'b1, 8'h00, 1'b1);
        up = 1'b0; #1;
        check("R8 tc after dir flip", W'(tc_n), W'(1'b0));

        // R4 / R9: bus drive gating
        sel_n = 1'b1; load_n = 1'b1; oe_n = 1'b0; #1;
        check("R4 deselected", W'(bus_oe), W'(1'b0));
        sel_n = 1'b0; load_n = 1'b1; oe_n = 1'b1; #1;
        check("R4 oe_n high", W'(bus_oe), W'(1'b0));
        sel_n = 1'b0; load_n = 1'b0; oe_n = 1'b0; cnt_en_p_n = 1'b1; #1;
        check("R9 no drive during load", W'(bus_oe), W'(1'b0));
        @(negedge clk);

        // R1: async clear between edges after loading a value
        sel_n = 1'b0; load_n = 1'b0; bus_in = 8'h3C; srst_n = 1'b1;
        @(negedge clk);
        read_back("R1 preload", 1'b1, 1'b1, 8'h3C, 1'b1);
        #3 rst_an = 1'b0;
        #1;
        check("R1 async clear", bus_out, 8'h00);
        @(negedge clk);
        rst_an = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule